// File: doc/BRIEF.md
# Acquisition Trigger Source Unit

This unit decides when an acquisition should start and sends a one-cycle trigger pulse to the acquisition sequencer. The pulse can come from three sources. Software can raise it by writing a strobe. An external trigger line can raise it on an edge whose direction is selectable. The selected one of four sample channels can raise it when its stream crosses a programmable threshold.

Software and hardware triggers have separate enables, and each source can work with the other disabled. One select bit chooses which hardware source is live, and a single polarity bit sets the direction for that source. A programmable delay, counted in sample-clock ticks, can hold the pulse back after the event is detected. The external line is asynchronous, so it is synchronised inside the unit before it is used.

Top module: `trig_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `trigOut` is low.
- R2: With `swEnable` = 1, each cycle in which `swTrigWr` is high counts as a software trigger event.
- R3: The software and hardware enables act independently. A software strobe with `swEnable` = 0 produces no pulse, and a hardware event with `hwEnable` = 1 fires even when `swEnable` = 0.
- R4: When `hwSourceSel` = 1 (external source), the line passes through a two-flop synchroniser and then an edge detector. A change applied in cycle C is seen as an event in cycle C+2. With `trigPolarity` = 0 only a low-to-high change counts; with `trigPolarity` = 1 only a high-to-low change counts.
- R5: When `hwSourceSel` = 0 (internal source) with `trigPolarity` = 0, an event occurs in a cycle with `sampleValid` = 1 when the selected channel's previous valid sample is below `threshold` and the new sample is at or above it, compared as unsigned numbers. The selected channel is index `chanSel` (0 to 3, the channel number minus one), held in bits [16*chanSel +: 16] of `sampleData`. Crossings on other channels are ignored.
- R6: On the internal source with `trigPolarity` = 1, an event occurs when the previous valid sample is at or above `threshold` and the new sample is below it.
- R7: Only the source picked by `hwSourceSel` can fire. External edges are ignored while the internal source is selected, and threshold crossings are ignored while the external source is selected.
- R8: With `hwEnable` = 0, hardware events produce no pulse, while software triggers still work.
- R9: The delay is captured when an event is accepted. An event in cycle C with a captured delay of D produces a one-cycle pulse in cycle C+D, so D = 0 gives a pulse in the same cycle. A change to `delayTicks` during a countdown has no effect on that countdown.
- R10: An event that arrives while a countdown is running is discarded. This includes an event in the same cycle the delayed pulse goes out. The first event after that cycle is accepted again.
- R11: The internal comparison works only on valid samples. The first valid sample after reset cannot fire, since it has no previous sample. A level that stays on one side of the threshold never fires again. Samples presented with `sampleValid` = 0 neither fire nor change the comparison history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleData | input | 64 | Four 16-bit channel samples, channel index i in bits [16*i +: 16] |
| sampleValid | input | 1 | Marks `sampleData` as a new sample set |
| extTrigIn | input | 1 | Asynchronous external trigger line |
| swTrigWr | input | 1 | Software trigger write strobe |
| swEnable | input | 1 | Software trigger enable |
| hwEnable | input | 1 | Hardware trigger enable |
| hwSourceSel | input | 1 | Hardware source select: 0 internal threshold, 1 external line |
| trigPolarity | input | 1 | 0 rising edge or crossing, 1 falling |
| chanSel | input | 2 | Channel index for the threshold comparison |
| threshold | input | 16 | Unsigned threshold level |
| delayTicks | input | 32 | Trigger delay in sample-clock ticks |
| trigOut | output | 1 | One-cycle trigger pulse to the sequencer |

## Verification
The hardest case to reach from the ports is an event that lands inside a running countdown, and in particular one that arrives in the same cycle the delayed pulse goes out. The bench reaches it by timing software strobes cycle by cycle against a known captured delay. It also rewrites `delayTicks` in the middle of the countdown to show that the captured value is the one that counts. Comparison history is the second subtle point. The bench reaches it with an extra reset, then sample streams that hold a level, skip invalid cycles, and cross on channels that are not selected.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Strobes that the control issues to the datapath delay counter
  typedef struct packed {
    logic loadDelay;  // capture delayTicks into the counter
    logic stepDelay;  // count one tick down
  } dly_ctl_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/trig_cross.sv
module trig_cross #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                polarity,
  output logic                crossEvt
);
  logic [SAMPLE_W-1:0] prevSample;
  logic                havePrev;
  logic                prevAbove;
  logic                curAbove;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      havePrev   <= 1'b0;
    end else if (valid) begin
      prevSample <= sample;
      havePrev   <= 1'b1;
    end
  end

  assign prevAbove = (prevSample >= threshold);
  assign curAbove  = (sample >= threshold);
  assign crossEvt  = valid && havePrev &&
                     (polarity ? (prevAbove && !curAbove) : (!prevAbove && curAbove));
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SAMPLE_W    = 16,
  parameter int DELAY_W     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CH_SEL_W   = $clog2(NUM_CH),
  localparam int DATA_W     = NUM_CH * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   sampleData,
  input  logic                sampleValid,
  input  logic                extTrigIn,
  input  logic                trigPolarity,
  input  logic                hwSourceSel,
  input  logic [CH_SEL_W-1:0] chanSel,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [DELAY_W-1:0]  delayTicks,
  input  dly_ctl_t            dlyCtl,
  output logic                hwEdge,
  output logic                delayIsZero,
  output logic                countAtOne,
  output logic [DELAY_W-1:0]  dlyCount
);
  logic [NUM_CH-1:0] crossVec;
  logic              extSync;
  logic              extLast;
  logic              extEdge;

  // Threshold comparators, one per channel so history survives channel switches
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    trig_cross #(.SAMPLE_W(SAMPLE_W)) u_cross (
      .clk      (clk),
      .rstN     (rstN),
      .sample   (sampleData[i*SAMPLE_W +: SAMPLE_W]),
      .valid    (sampleValid),
      .threshold(threshold),
      .polarity (trigPolarity),
      .crossEvt (crossVec[i])
    );
  end

  // External line: synchroniser then edge detect
  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (extTrigIn),
    .dout(extSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extLast <= 1'b0;
    else       extLast <= extSync;
  end

  assign extEdge = trigPolarity ? (extLast && !extSync) : (!extLast && extSync);
  assign hwEdge  = hwSourceSel ? extEdge : crossVec[chanSel];

  // Delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dlyCount <= '0;
    else if (dlyCtl.loadDelay) dlyCount <= delayTicks;
    else if (dlyCtl.stepDelay) dlyCount <= dlyCount - DELAY_W'(1);
  end

  assign delayIsZero = (delayTicks == '0);
  assign countAtOne  = (dlyCount == DELAY_W'(1));
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hwEdge,
  input  logic     hwEnable,
  input  logic     swTrigWr,
  input  logic     swEnable,
  input  logic     delayIsZero,
  input  logic     countAtOne,
  output dly_ctl_t dlyCtl,
  output logic     busy,
  output logic     evt,
  output logic     trigOut
);
  logic accept;

  assign evt    = (hwEnable && hwEdge) || (swEnable && swTrigWr);
  assign accept = !busy && evt;

  always_comb begin
    dlyCtl           = '0;
    dlyCtl.loadDelay = accept && !delayIsZero;
    dlyCtl.stepDelay = busy;
  end

  assign trigOut = (accept && delayIsZero) || (busy && countAtOne);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  busy <= 1'b0;
    else if (dlyCtl.loadDelay)  busy <= 1'b1;
    else if (busy && countAtOne) busy <= 1'b0;
  end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SAMPLE_W    = 16,
  parameter int DELAY_W     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CH_SEL_W   = $clog2(NUM_CH),
  localparam int DATA_W     = NUM_CH * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   sampleData,
  input  logic                sampleValid,
  input  logic                extTrigIn,
  input  logic                swTrigWr,
  input  logic                swEnable,
  input  logic                hwEnable,
  input  logic                hwSourceSel,
  input  logic                trigPolarity,
  input  logic [CH_SEL_W-1:0] chanSel,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [DELAY_W-1:0]  delayTicks,
  output logic                trigOut
);
  dly_ctl_t           dlyCtl;
  logic               hwEdge;
  logic               delayIsZero;
  logic               countAtOne;
  logic [DELAY_W-1:0] dlyCount;
  logic               ctlBusy;
  logic               ctlEvt;

  trig_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DELAY_W(DELAY_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .extTrigIn   (extTrigIn),
    .trigPolarity(trigPolarity),
    .hwSourceSel (hwSourceSel),
    .chanSel     (chanSel),
    .threshold   (threshold),
    .delayTicks  (delayTicks),
    .dlyCtl      (dlyCtl),
    .hwEdge      (hwEdge),
    .delayIsZero (delayIsZero),
    .countAtOne  (countAtOne),
    .dlyCount    (dlyCount)
  );

  trig_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .hwEdge     (hwEdge),
    .hwEnable   (hwEnable),
    .swTrigWr   (swTrigWr),
    .swEnable   (swEnable),
    .delayIsZero(delayIsZero),
    .countAtOne (countAtOne),
    .dlyCtl     (dlyCtl),
    .busy       (ctlBusy),
    .evt        (ctlEvt),
    .trigOut    (trigOut)
  );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk #(
  parameter int DELAY_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               trigOut,
  input logic               busy,
  input logic               evt,
  input logic               swEnable,
  input logic               hwEnable,
  input logic [DELAY_W-1:0] delayTicks,
  input logic [DELAY_W-1:0] count
);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !swEnable && !hwEnable) |-> !trigOut);

  // R9
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && evt && delayTicks == '0) |-> trigOut);

  // R9
  delay_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && evt && delayTicks != '0) |=> (busy && count == $past(delayTicks)));

  // R10
  countdown_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && count != DELAY_W'(1)) |=> (busy && count == $past(count) - DELAY_W'(1)));

  // R9
  expiry_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && count == DELAY_W'(1)) |-> trigOut);

  // R10
  expiry_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && count == DELAY_W'(1)) |=> !busy);
endmodule

bind trig_unit trig_unit_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trigOut   (trigOut),
  .busy      (ctlBusy),
  .evt       (ctlEvt),
  .swEnable  (swEnable),
  .hwEnable  (hwEnable),
  .delayTicks(delayTicks),
  .count     (dlyCount)
);

// File: tb/sim_trig_unit.sv
module sim_trig_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        extTrigIn = 1'b0;
  logic        swTrigWr = 1'b0;
  logic        swEnable = 1'b0;
  logic        hwEnable = 1'b0;
  logic        hwSourceSel = 1'b0;
  logic        trigPolarity = 1'b0;
  logic [1:0]  chanSel = '0;
  logic [15:0] threshold = '0;
  logic [31:0] delayTicks = '0;
  logic        trigOut;

  trig_unit u0 (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
    .extTrigIn(extTrigIn), .swTrigWr(swTrigWr), .swEnable(swEnable), .hwEnable(hwEnable),
    .hwSourceSel(hwSourceSel), .trigPolarity(trigPolarity), .chanSel(chanSel),
    .threshold(threshold), .delayTicks(delayTicks), .trigOut(trigOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int unsigned cyc; string tag; } exp_t;
  exp_t        expQ[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          unexpCnt = 0;
  int          quietBase = 0;
  string       quietTag = "R2";
  bit          monOn = 1'b0;
  logic        expNow;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each cycle's pulse against the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      expNow = (expQ.size() > 0) && (expQ[0].cyc == cyc);
      if (expNow) begin
        checks++;
        if (trigOut !== 1'b1) begin
          fails++;
          $display("FAIL %s: pulse at cycle %0d actual=%b expected=1", expQ[0].tag, cyc, trigOut);
        end
        void'(expQ.pop_front());
      end else if (trigOut !== 1'b0) begin
        checks++;
        fails++;
        unexpCnt++;
        $display("FAIL %s: stray pulse at cycle %0d actual=%b expected=0", quietTag, cyc, trigOut);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic void expectAt(int unsigned c, string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    expQ.push_back(e);
  endfunction

  task automatic beginQuiet(string tag);
    quietTag  = tag;
    quietBase = unexpCnt;
  endtask

  task automatic endQuiet(int n);
    repeat (n) tick();
    checks++;
    if (unexpCnt != quietBase) begin
      fails++;
      $display("FAIL %s: stray pulses in window actual=%0d expected=0", quietTag, unexpCnt - quietBase);
    end
  endtask

  task automatic swWrite(bit expectIt, int unsigned offs, string tag);
    swTrigWr = 1'b1;
    if (expectIt) expectAt(cyc + offs, tag);
    tick();
    swTrigWr = 1'b0;
  endtask

  task automatic sendSamples(logic [15:0] c0, logic [15:0] c1, logic [15:0] c2, logic [15:0] c3);
    sampleData  = {c3, c2, c1, c0};
    sampleValid = 1'b1;
    tick();
    sampleValid = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (trigOut !== 1'b0) begin
        fails++;
        $display("FAIL R1: trigOut in reset actual=%b expected=0", trigOut);
      end
    end
    tick();
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (trigOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: trigOut after reset actual=%b expected=0", trigOut);
    end
    monOn = 1'b1;
    tick();

    // R2: software trigger, zero delay
    swEnable = 1'b1;
    swWrite(1, 0, "R2");
    repeat (3) tick();
    swWrite(1, 0, "R2");
    repeat (2) tick();

    // R3: software disabled
    swEnable = 1'b0;
    beginQuiet("R3");
    swWrite(0, 0, "R3");
    endQuiet(4);

    // R3/R4: hardware alone, external rising edge
    hwEnable = 1'b1; hwSourceSel = 1'b1; trigPolarity = 1'b0;
    extTrigIn = 1'b1;
    expectAt(cyc + 2, "R4");
    repeat (5) tick();
    beginQuiet("R4");
    extTrigIn = 1'b0;
    endQuiet(5);
    trigPolarity = 1'b1;
    beginQuiet("R4");
    extTrigIn = 1'b1;
    endQuiet(5);
    extTrigIn = 1'b0;
    expectAt(cyc + 2, "R4");
    repeat (5) tick();
    trigPolarity = 1'b0;

    // R7: internal crossing ignored while external is selected
    threshold = 16'h0100; chanSel = 2'd0;
    beginQuiet("R7");
    sendSamples(16'h0010, 16'h0010, 16'h0050, 16'h0010);
    sendSamples(16'h0200, 16'h0010, 16'h0050, 16'h0010);
    endQuiet(3);
    // R7: external edge ignored while internal is selected
    hwSourceSel = 1'b0;
    beginQuiet("R7");
    extTrigIn = 1'b1;
    repeat (4) tick();
    extTrigIn = 1'b0;
    endQuiet(4);

    // R5: channel index 2 crosses upward, reaching threshold exactly; ch1 crosses too
    chanSel = 2'd2;
    expectAt(cyc, "R5");
    sendSamples(16'h0010, 16'h0200, 16'h0100, 16'h0010);
    // R11: held level, invalid samples, downward crossing with polarity 0
    beginQuiet("R11");
    sendSamples(16'h0010, 16'h0200, 16'h0200, 16'h0010);
    sampleData = {16'h0010, 16'h0020, 16'h0200, 16'h0010};
    tick();
    sampleData = {16'h0010, 16'h0300, 16'h0200, 16'h0010};
    tick();
    sendSamples(16'h0010, 16'h0200, 16'h0060, 16'h0010);
    endQuiet(2);

    // R6: falling crossing with polarity 1
    trigPolarity = 1'b1;
    beginQuiet("R6");
    sendSamples(16'h0010, 16'h0200, 16'h0180, 16'h0010);
    sendSamples(16'h0010, 16'h0010, 16'h0180, 16'h0010);
    endQuiet(2);
    expectAt(cyc, "R6");
    sendSamples(16'h0010, 16'h0010, 16'h00FF, 16'h0010);
    repeat (2) tick();
    trigPolarity = 1'b0;

    // R8: hardware disabled, software still works
    hwEnable = 1'b0; swEnable = 1'b1; hwSourceSel = 1'b1;
    beginQuiet("R8");
    extTrigIn = 1'b1;
    endQuiet(5);
    extTrigIn = 1'b0;
    repeat (4) tick();
    swWrite(1, 0, "R8");
    repeat (2) tick();

    // R9: delayed pulses
    quietTag = "R9";
    delayTicks = 32'd5;
    swWrite(1, 5, "R9");
    repeat (8) tick();
    delayTicks = 32'd1;
    swWrite(1, 1, "R9");
    repeat (3) tick();

    // R10: events during a countdown, including the expiry cycle
    beginQuiet("R10");
    delayTicks = 32'd4;
    swWrite(1, 4, "R10");       // accepted at C, pulse at C+4
    delayTicks = 32'd1;         // R9: mid-count change has no effect
    tick();
    swWrite(0, 0, "R10");       // C+2, discarded
    tick();
    swWrite(0, 0, "R10");       // C+4, expiry cycle, discarded
    swWrite(1, 1, "R10");       // C+5, accepted with delay 1
    endQuiet(3);
    delayTicks = 32'd0;

    // R11: first valid sample after reset cannot fire
    monOn = 1'b0;
    rstN = 1'b0;
    repeat (2) tick();
    rstN = 1'b1;
    tick();
    monOn = 1'b1;
    hwEnable = 1'b1; swEnable = 1'b0; hwSourceSel = 1'b0;
    chanSel = 2'd2; threshold = 16'h0100; trigPolarity = 1'b0;
    beginQuiet("R11");
    sendSamples(16'h0000, 16'h0000, 16'h0300, 16'h0000);
    sendSamples(16'h0000, 16'h0000, 16'h0300, 16'h0000);
    endQuiet(3);
    sendSamples(16'h0000, 16'h0000, 16'h0020, 16'h0000);
    expectAt(cyc, "R11");
    sendSamples(16'h0000, 16'h0000, 16'h0100, 16'h0000);
    repeat (4) tick();

    while (expQ.size() > 0) begin
      checks++;
      fails++;
      $display("FAIL %s: pulse due at cycle %0d actual=missing expected=pulse", expQ[0].tag, expQ[0].cyc);
      void'(expQ.pop_front());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule